// File: doc/BRIEF.md
# Soft-Start and Soft-Skip Envelope Controller

This block computes the digital modulation level that sets the peak-current ceiling of a fixed-frequency current-mode converter. It also decides whether the gate drive may switch. A feedback code arrives from an external converter. The modulation level is the lower of two values: an internal envelope ramp, and the feedback code divided by three. One ramp length is used at power-up. A much shorter ramp is used when switching resumes after a skip-cycle period, which keeps audible noise and component stress low.

The skip-cycle decision depends on the region the skip/latch pin sits in, which three threshold flags report. In the lowest region an external level code is the skip threshold. In the next region the drive always skips. Above the reset level the pin counts as unconnected and a built-in default threshold applies. Above the latch level a latch request is raised. When feedback comes back from skip above the heavy-load level, the short ramp is bypassed and full modulation is applied at once.

The controller is a five-state machine. OFF has the drive disabled and waits for a start trigger. SOFT runs the long ramp. RUN is the full envelope. SKIP has the drive disabled. SRAMP runs the short ramp. Its transitions are:
- start trigger: from any state to SOFT, with the ramp counter cleared;
- skip entry: from SOFT, RUN or SRAMP to SKIP when the skip condition holds;
- ramp done: from SOFT or SRAMP to RUN when the ramp counter reaches its length;
- light exit: from SKIP to SRAMP when the skip condition clears and feedback is at or below the heavy-load level;
- heavy exit: from SKIP to RUN when the skip condition clears and feedback is above that level.

Top module: `ssk_envelope`

## Requirements
- R1: After reset the block is in OFF: `drive_en` is 0 and `mod_code` is 0. It stays there, whatever the feedback, until `ss_trig` is seen at a clock edge.
- R2: After a trigger, the envelope equals floor(n·RAMP_FULL/LONG_TICKS), where n is the number of `tick` pulses counted since the trigger edge, capped at LONG_TICKS. After the cap the envelope holds at RAMP_FULL. Cycles without `tick` do not advance it.
- R3: While `drive_en` is 1, `mod_code` is the smaller of the envelope and floor(`fb_code`/3).
- R4: When the skip condition holds at a clock edge and no trigger is present, `drive_en` and `mod_code` are 0 from that edge onward.
- R5: When the skip condition clears with `fb_code` at or below TLD (285 by default), drive resumes with an envelope of floor(n·RAMP_FULL/SHORT_TICKS). Here n counts ticks from that edge, up to SHORT_TICKS, and the envelope then holds at RAMP_FULL.
- R6: When the skip condition clears with `fb_code` above TLD, the envelope is RAMP_FULL from the next edge on.
- R7: Region decode, with latch over reset over mid in priority. The adjust region has all flags at 0, and there the threshold is `skip_lvl`. The force region has only `pin_ovr_mid` set, and there the drive always skips. The open region has `pin_ovr_rst` set and `pin_ovr_lat` clear, and there the threshold is 120 (1.2 V at 10 mV per code). The skip condition is `fb_code` below the threshold.
- R8: `latch_req` is 1 in the same cycle that `pin_ovr_lat` is 1, and 0 otherwise. The skip threshold in that region is the default 120.
- R9: In the adjust region, a `skip_lvl` of 0 never causes a skip. A `skip_lvl` of 300 or more (3.0 V) always causes a skip.
- R10: A trigger in any state, including during the short ramp, restarts the long ramp from zero. The next cycle shows `drive_en`=1 and `mod_code`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Ramp time-base pulse, one cycle wide |
| ss_trig | input | 1 | Soft-start trigger |
| fb_code | input | 10 | Feedback code, 10 mV per step |
| skip_lvl | input | 10 | Skip-pin level code, same scale as feedback |
| pin_ovr_mid | input | 1 | Skip pin above the 3.0 V equivalent |
| pin_ovr_rst | input | 1 | Skip pin above the skip-reset level |
| pin_ovr_lat | input | 1 | Skip pin above the latch level |
| mod_code | output | 10 | Modulation level, RAMP_FULL means 1.0 V |
| drive_en | output | 1 | Gate drive permitted |
| latch_req | output | 1 | Latch-off request |

## Verification
Both outputs come from the registered state and the ramp counter, so a wrong state shows up at the ports one edge after the decision. A missed skip entry leaves `drive_en` high. A wrong skip exit shows either a full envelope where a short ramp is expected, or the reverse. A counter that is off by one, or that advances without a tick, changes `mod_code` at the very next tick, while feedback is held above three times RAMP_FULL so that the envelope sets the output. A cycle-accurate model in the bench checks every cycle, so a divergence is reported in the cycle it first appears.

// File: rtl/ssk_pkg.sv
package ssk_pkg;

    typedef enum logic [2:0] {
        S_OFF   = 3'd0,
        S_SOFT  = 3'd1,
        S_RUN   = 3'd2,
        S_SKIP  = 3'd3,
        S_SRAMP = 3'd4
    } env_state_e;

    typedef enum logic [1:0] {
        REG_ADJ   = 2'd0,
        REG_FORCE = 2'd1,
        REG_OPEN  = 2'd2,
        REG_LATCH = 2'd3
    } pin_region_e;

endpackage

// File: rtl/ssk_region_dec.sv
module ssk_region_dec
    import ssk_pkg::*;
#(
    parameter int CODE_W    = 10,
    parameter int RAMP_FULL = 100
) (
    input  logic              pin_ovr_mid,
    input  logic              pin_ovr_rst,
    input  logic              pin_ovr_lat,
    input  logic [CODE_W-1:0] skip_lvl,
    input  logic [CODE_W-1:0] fb_code,
    output pin_region_e       region,
    output logic              skip_req
);

    // Default threshold is 1.2 V; a pin level at or above 3.0 V means "always skip".
    localparam logic [CODE_W-1:0] DEF_SKIP = CODE_W'((RAMP_FULL * 6) / 5);
    localparam logic [CODE_W-1:0] SKIP_ALL = CODE_W'(RAMP_FULL * 3);

    always_comb begin
        if (pin_ovr_lat)      region = REG_LATCH;
        else if (pin_ovr_rst) region = REG_OPEN;
        else if (pin_ovr_mid) region = REG_FORCE;
        else                  region = REG_ADJ;
    end

    always_comb begin
        unique case (region)
            REG_ADJ:   skip_req = (skip_lvl >= SKIP_ALL) || (fb_code < skip_lvl);
            REG_FORCE: skip_req = 1'b1;
            REG_OPEN,
            REG_LATCH: skip_req = (fb_code < DEF_SKIP);
            default:   skip_req = 1'b1;
        endcase
    end

endmodule

// File: rtl/ssk_ramp_gen.sv
module ssk_ramp_gen #(
    parameter int CODE_W      = 10,
    parameter int RAMP_FULL   = 100,
    parameter int LONG_TICKS  = 40,
    parameter int SHORT_TICKS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              tick,
    input  logic              short_sel,
    output logic [CODE_W-1:0] value,
    output logic              done
);

    localparam int CNT_W = $clog2(LONG_TICKS + 1);
    localparam logic [CNT_W-1:0] LONG_LIM  = CNT_W'(LONG_TICKS);
    localparam logic [CNT_W-1:0] SHORT_LIM = CNT_W'(SHORT_TICKS);
    localparam logic [CODE_W-1:0] FULL     = CODE_W'(RAMP_FULL);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;
    logic [31:0]      prod;

    assign lim  = short_sel ? SHORT_LIM : LONG_LIM;
    assign done = (cnt == lim);
    assign prod = 32'(cnt) * 32'(RAMP_FULL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt <= '0;
        else if (clr)              cnt <= '0;
        else if (tick && cnt < lim) cnt <= cnt + 1'b1;
    end

    // Exact division by the selected length; both divisors are constants.
    always_comb begin
        if (short_sel) value = CODE_W'(prod / 32'(SHORT_TICKS));
        else           value = CODE_W'(prod / 32'(LONG_TICKS));
    end

    // R2
    hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !tick) |=> $stable(cnt));

    // R2
    long_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!short_sel && done) |-> (value == FULL));

    // R5
    short_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (short_sel && done) |-> (value == FULL));

endmodule

// File: rtl/ssk_envelope.sv
module ssk_envelope
    import ssk_pkg::*;
#(
    parameter int CODE_W      = 10,
    parameter int RAMP_FULL   = 100,
    parameter int LONG_TICKS  = 40,
    parameter int SHORT_TICKS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              ss_trig,
    input  logic [CODE_W-1:0] fb_code,
    input  logic [CODE_W-1:0] skip_lvl,
    input  logic              pin_ovr_mid,
    input  logic              pin_ovr_rst,
    input  logic              pin_ovr_lat,
    output logic [CODE_W-1:0] mod_code,
    output logic              drive_en,
    output logic              latch_req
);

    // Heavy-load level: 2.85 V on the feedback scale.
    localparam logic [CODE_W-1:0] TLD_CODE = CODE_W'((RAMP_FULL * 57) / 20);
    localparam logic [CODE_W-1:0] FULL     = CODE_W'(RAMP_FULL);

    env_state_e        state, nxt;
    pin_region_e       region;
    logic              skip_req;
    logic              ramp_clr;
    logic              ramp_done;
    logic [CODE_W-1:0] ramp_val;
    logic [CODE_W-1:0] fb_div3;
    logic [CODE_W-1:0] env;

    ssk_region_dec #(.CODE_W(CODE_W), .RAMP_FULL(RAMP_FULL)) u_dec (
        .pin_ovr_mid (pin_ovr_mid),
        .pin_ovr_rst (pin_ovr_rst),
        .pin_ovr_lat (pin_ovr_lat),
        .skip_lvl    (skip_lvl),
        .fb_code     (fb_code),
        .region      (region),
        .skip_req    (skip_req)
    );

    ssk_ramp_gen #(
        .CODE_W(CODE_W), .RAMP_FULL(RAMP_FULL),
        .LONG_TICKS(LONG_TICKS), .SHORT_TICKS(SHORT_TICKS)
    ) u_ramp (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (ramp_clr),
        .tick      (tick),
        .short_sel (state == S_SRAMP),
        .value     (ramp_val),
        .done      (ramp_done)
    );

    // Next state and ramp clear
    always_comb begin
        nxt      = state;
        ramp_clr = 1'b0;
        if (ss_trig) begin
            nxt      = S_SOFT;
            ramp_clr = 1'b1;
        end else begin
            unique case (state)
                S_OFF: nxt = S_OFF;
                S_SOFT: begin
                    if (skip_req)       nxt = S_SKIP;
                    else if (ramp_done) nxt = S_RUN;
                end
                S_RUN: begin
                    if (skip_req) nxt = S_SKIP;
                end
                S_SKIP: begin
                    if (!skip_req) begin
                        if (fb_code > TLD_CODE) begin
                            nxt = S_RUN;
                        end else begin
                            nxt      = S_SRAMP;
                            ramp_clr = 1'b1;
                        end
                    end
                end
                S_SRAMP: begin
                    if (skip_req)       nxt = S_SKIP;
                    else if (ramp_done) nxt = S_RUN;
                end
                default: nxt = S_OFF;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_OFF;
        else        state <= nxt;
    end

    // Outputs
    assign fb_div3 = fb_code / CODE_W'(3);

    always_comb begin
        drive_en = 1'b0;
        env      = '0;
        unique case (state)
            S_SOFT, S_SRAMP: begin drive_en = 1'b1; env = ramp_val; end
            S_RUN:           begin drive_en = 1'b1; env = FULL;     end
            S_OFF, S_SKIP:   begin drive_en = 1'b0; env = '0;       end
            default:         begin drive_en = 1'b0; env = '0;       end
        endcase
        mod_code  = (env < fb_div3) ? env : fb_div3;
        latch_req = (region == REG_LATCH);
    end

    // R3
    mod_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en |-> (mod_code <= FULL && mod_code <= fb_div3));

    // R4
    skip_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (skip_req && !ss_trig) |=> (!drive_en && mod_code == '0));

    // R6
    tld_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SKIP && !skip_req && fb_code > TLD_CODE && !ss_trig) |=> (state == S_RUN));

    // R7
    force_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_ovr_mid && !pin_ovr_rst && !pin_ovr_lat && !ss_trig) |=> !drive_en);

    // R9
    zero_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RUN && !pin_ovr_mid && !pin_ovr_rst && !pin_ovr_lat
         && skip_lvl == '0) |=> drive_en);

    // R10
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ss_trig |=> (drive_en && mod_code == '0));

    // R1
    off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_OFF && !ss_trig) |=> !drive_en);

endmodule

// File: tb/tb_ssk_envelope.sv
`timescale 1ns/1ps
module tb_ssk_envelope;

    localparam int FULL  = 100;
    localparam int LONGT = 40;
    localparam int SHRT  = 3;
    localparam int TLD   = 285;
    localparam int DEFS  = 120;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       ss_trig = 1'b0;
    logic [9:0] fb_code = '0;
    logic [9:0] skip_lvl = '0;
    logic       pin_ovr_mid = 1'b0;
    logic       pin_ovr_rst = 1'b0;
    logic       pin_ovr_lat = 1'b0;
    logic [9:0] mod_code;
    logic       drive_en;
    logic       latch_req;

    int total = 0;
    int bad = 0;

    // model: 0 off, 1 soft, 2 run, 3 skip, 4 sramp
    int m_st = 0;
    int m_cnt = 0;

    always #2.5 clk = ~clk;

    ssk_envelope dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ss_trig(ss_trig),
        .fb_code(fb_code), .skip_lvl(skip_lvl),
        .pin_ovr_mid(pin_ovr_mid), .pin_ovr_rst(pin_ovr_rst), .pin_ovr_lat(pin_ovr_lat),
        .mod_code(mod_code), .drive_en(drive_en), .latch_req(latch_req)
    );

    function automatic bit f_skip();
        if (pin_ovr_lat || pin_ovr_rst) return int'(fb_code) < DEFS;
        if (pin_ovr_mid) return 1'b1;
        return (int'(skip_lvl) >= 3 * FULL) || (fb_code < skip_lvl);
    endfunction

    function automatic bit f_drive();
        return (m_st == 1) || (m_st == 2) || (m_st == 4);
    endfunction

    function automatic int f_mod();
        int env;
        int d3;
        if (!f_drive()) return 0;
        if (m_st == 2)      env = FULL;
        else if (m_st == 1) env = (m_cnt * FULL) / LONGT;
        else                env = (m_cnt * FULL) / SHRT;
        d3 = int'(fb_code) / 3;
        return (env < d3) ? env : d3;
    endfunction

    task automatic m_step();
        int  lim;
        bit  sk;
        bit  clr;
        int  nst;
        sk  = f_skip();
        lim = (m_st == 4) ? SHRT : LONGT;
        clr = 1'b0;
        nst = m_st;
        if (ss_trig) begin
            nst = 1; clr = 1'b1;
        end else begin
            case (m_st)
                1: if (sk) nst = 3; else if (m_cnt == lim) nst = 2;
                2: if (sk) nst = 3;
                3: if (!sk) begin
                       if (int'(fb_code) > TLD) nst = 2;
                       else begin nst = 4; clr = 1'b1; end
                   end
                4: if (sk) nst = 3; else if (m_cnt == lim) nst = 2;
                default: nst = m_st;
            endcase
        end
        if (clr) m_cnt = 0;
        else if (tick && m_cnt < lim) m_cnt = m_cnt + 1;
        m_st = nst;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    function automatic string state_tag();
        case (m_st)
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R5";
            default: return "R1";
        endcase
    endfunction

    // inputs are set at the falling edge; one rising edge; outputs compared 1 ns later
    task automatic cyc(input string tag);
        string t;
        @(posedge clk);
        m_step();
        #1;
        t = (tag == "") ? state_tag() : tag;
        chk({t, " mod_code"}, int'(mod_code), f_mod());
        chk({t, " drive_en"}, int'(drive_en), int'(f_drive()));
        chk("R8 latch_req", int'(latch_req), int'(pin_ovr_lat));
        @(negedge clk);
        ss_trig = 1'b0;
    endtask

    task automatic pins(input bit a, input bit b, input bit c);
        pin_ovr_mid = a; pin_ovr_rst = b; pin_ovr_lat = c;
    endtask

    initial begin
        #900000;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4211));
        fb_code = 10'd1023;
        pins(1'b1, 1'b1, 1'b0);
        #12;
        // R1 reset state
        chk("R1 reset drive_en", int'(drive_en), 0);
        chk("R1 reset mod_code", int'(mod_code), 0);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 stays off without trigger
        tick = 1'b1;
        repeat (5) cyc("R1");

        // R2 long ramp with feedback well above the envelope
        ss_trig = 1'b1;
        cyc("R2");
        for (int i = 0; i < LONGT + 6; i++) begin
            tick = (i % 3 != 2);
            cyc("R2");
        end
        tick = 1'b1;
        repeat (4) cyc("R2");

        // R3 feedback limits the level
        fb_code = 10'd150; cyc("R3");
        fb_code = 10'd200; cyc("R3");
        fb_code = 10'd121; cyc("R3");

        // R7 open region default threshold: 119 skips, 120 does not
        fb_code = 10'd119; cyc("R7");
        cyc("R4");
        // R5 short ramp on light exit
        fb_code = 10'd280;
        for (int i = 0; i < 6; i++) cyc("R5");

        // R6 heavy exit
        fb_code = 10'd100; cyc("R4"); cyc("R4");
        fb_code = 10'd300; cyc("R6"); cyc("R6");
        fb_code = 10'd100; cyc("R4");
        fb_code = 10'd285; cyc("R6"); cyc("R5");

        // R10 trigger during short ramp
        tick = 1'b0;
        fb_code = 10'd100; cyc("R4");
        fb_code = 10'd250; cyc("R5");
        ss_trig = 1'b1; cyc("R10");
        tick = 1'b1;
        fb_code = 10'd1023;
        for (int i = 0; i < 5; i++) cyc("R10");

        // R7 force region
        pins(1'b1, 1'b0, 1'b0); cyc("R7"); cyc("R7");
        // R7 adjust region with level 200
        pins(1'b0, 1'b0, 1'b0); skip_lvl = 10'd200;
        fb_code = 10'd150; cyc("R7");
        fb_code = 10'd250; cyc("R7"); cyc("R7");
        // R9 zero threshold never skips
        skip_lvl = 10'd0; fb_code = 10'd0;
        for (int i = 0; i < 4; i++) cyc("R9");
        fb_code = 10'd500; repeat (4) cyc("R9");
        // R9 threshold 3.0 V always skips
        skip_lvl = 10'd300; fb_code = 10'd1023; cyc("R9"); cyc("R9");
        // R8 latch region
        pins(1'b1, 1'b1, 1'b1); fb_code = 10'd1023; cyc("R8"); cyc("R8");
        fb_code = 10'd50; cyc("R8");
        pins(1'b0, 1'b0, 1'b0); skip_lvl = 10'd100;

        // random mix
        for (int n = 0; n < 4000; n++) begin
            int r;
            tick = ($urandom_range(0, 1) == 1);
            ss_trig = ($urandom_range(0, 299) == 0);
            if ($urandom_range(0, 7) == 0) begin
                r = $urandom_range(0, 3);
                case (r)
                    0: fb_code = 10'($urandom_range(0, 119));
                    1: fb_code = 10'($urandom_range(120, 285));
                    2: fb_code = 10'($urandom_range(286, 1023));
                    default: fb_code = 10'($urandom_range(0, 1023));
                endcase
            end
            if ($urandom_range(0, 99) == 0) begin
                r = $urandom_range(0, 9);
                if (r < 5)       pins(1'b0, 1'b0, 1'b0);
                else if (r < 8)  pins(1'b1, 1'b1, 1'b0);
                else if (r == 8) pins(1'b1, 1'b0, 1'b0);
                else             pins(1'b1, 1'b1, 1'b1);
                skip_lvl = 10'($urandom_range(0, 320));
            end
            cyc("");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule